// File: doc/BRIEF.md
# Ping-Pong Data Buffer Port

This block sits between a 32-bit software data port and the card-side data engine of a memory-card host. Two word buffers, X (buffer 0) and Y (buffer 1), take turns. One side fills a buffer while the other side empties the buffer that was filled before it. In the write direction, software is the producer and the card side is the consumer. In the read direction, the roles swap. The serial engine and its CRC logic are outside the block; here they appear as a plain word stream with a valid/ready pair.

A transfer starts with a one-cycle `start` pulse, which latches the direction, the block length in bytes and the block count. The transfer moves ceil(length × count / 4) words, so a trailing partial word travels as one full padded word. A buffer passes to its consumer when it holds `DEPTH` words, or earlier when the last word of the transfer enters it. The 32-bit status word shows readiness, per-buffer occupancy, sticky error bits and sticky completion bits. Software clears each sticky bit by writing 1 to it.

Top module: `dbuf_port`

## Requirements
- R1: After reset, status reads 0x3000_0000: both buffers are empty and no ready, error or done bit is set.
- R2: A `start` pulse loads a transfer of ceil(blkLen × blkCnt / 4) words. Exactly that many words are accepted from the producer and delivered to the consumer. When the product is zero, the done bit for the chosen direction is set after that edge and no ready bit rises.
- R3: In the write direction (`dirWrite`=1), status bit 6 is high while the current fill buffer has room and words remain. Every word written by software while bit 6 is high appears at `cardOutData` in the same order, first from X and then alternating with Y.
- R4: In the read direction, words taken from `cardInData` while `cardInReady` is high are returned on `rdData` in the same order, while status bit 7 is high. `cardOutValid` and `cardInReady` are never high together.
- R5: Status bits 28/29 are high when X/Y hold no words. Bits 26/27 are high when X/Y hold `DEPTH` words.
- R6: A software write while status bit 6 is low sets sticky overflow bit 24 and stores nothing.
- R7: A software read while status bit 7 is low sets sticky underrun bit 25 and consumes nothing.
- R8: Sticky bit 12 is set when the card side takes the last word of a write transfer. Sticky bit 11 is set when software reads the last word of a read transfer.
- R9: A clear cycle drops exactly the sticky bits 25, 24, 12 and 11 whose mask bit is 1. A set event in the same cycle wins over the clear. Occupancy and ready bits are not affected.
- R10: In the same cycle, the producer can push into one buffer while the consumer pops from the other.
- R11: When the final word leaves a buffer short of `DEPTH` words, that buffer still passes to the consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the settings below |
| dirWrite | input | 1 | 1: software to card, 0: card to software |
| blkLen | input | 12 | Block length in bytes |
| blkCnt | input | 16 | Number of blocks |
| swWr | input | 1 | Software word write strobe |
| wrData | input | 32 | Software write word |
| swRd | input | 1 | Software word read strobe |
| rdData | output | 32 | Word at the head of the consumer buffer |
| clrEn | input | 1 | Status clear strobe |
| clrMask | input | 32 | Write-1-to-clear mask |
| status | output | 32 | Status word |
| cardOutValid | output | 1 | Word available for the card side (write direction) |
| cardOutData | output | 32 | Word offered to the card side |
| cardOutTake | input | 1 | Card side takes the offered word |
| cardInValid | input | 1 | Card side offers a word (read direction) |
| cardInData | input | 32 | Word from the card side |
| cardInReady | output | 1 | Block accepts a card-side word |

## Verification
A producer push and a consumer pop can happen on the same edge, in opposite buffers. The pop can also empty and hand back one buffer in the cycle in which the push seals the other. Random transfers run both sides at high activity rates so that these collisions happen often. The bench counts the cycles in which both strobes were accepted and requires that count to be nonzero. It then judges the outcome by the word order, the word total and the done bit, all against a queue kept by the bench.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;     // write one word into buffer prodSel
    logic pop;      // advance head of buffer consSel
    logic prodSel;  // buffer being filled
    logic consSel;  // buffer being drained
    logic relBuf;   // consSel buffer drained: rewind its pointers
    logic flush;    // new transfer: rewind everything
  } bufCtl_t;

  localparam int ST_RD_RDY  = 7;
  localparam int ST_WR_RDY  = 6;
  localparam int ST_RD_DONE = 11;
  localparam int ST_WR_DONE = 12;
  localparam int ST_OVF     = 24;
  localparam int ST_UND     = 25;
  localparam int ST_X_FULL  = 26;
  localparam int ST_Y_FULL  = 27;
  localparam int ST_X_EMPTY = 28;
  localparam int ST_Y_EMPTY = 29;
endpackage

// File: rtl/dbuf_datapath.sv
module dbuf_datapath
  import dbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bufCtl_t           ctl,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] headData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] headB [2];

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [DATA_W-1:0] store [DEPTH];
    logic [PW-1:0]     wrPtr;
    logic [PW-1:0]     rdPtr;
    logic              pushHere;
    logic              popHere;
    logic              rewind;

    assign pushHere = ctl.push && (ctl.prodSel == 1'(b));
    assign popHere  = ctl.pop  && (ctl.consSel == 1'(b));
    assign rewind   = ctl.flush || (ctl.relBuf && (ctl.consSel == 1'(b)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else if (rewind) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (pushHere) wrPtr <= wrPtr + 1'b1;
        if (popHere)  rdPtr <= rdPtr + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (pushHere && !ctl.flush) store[wrPtr] <= pushData;
    end

    assign headB[b] = store[rdPtr];
  end

  assign headData = headB[ctl.consSel];
endmodule

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
  import dbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dirWrite,
  input  logic [LEN_W-1:0] blkLen,
  input  logic [CNT_W-1:0] blkCnt,
  input  logic             swWr,
  input  logic             swRd,
  input  logic             clrEn,
  input  logic [31:0]      clrMask,
  input  logic             cardOutTake,
  input  logic             cardInValid,
  output bufCtl_t          ctl,
  output logic             dirQ,
  output logic [31:0]      status,
  output logic             cardOutValid,
  output logic             cardInReady
);
  localparam int TOT_W = LEN_W + CNT_W;
  localparam int CB    = $clog2(DEPTH + 1);

  logic             active;
  logic             prodSel, consSel;
  logic [1:0]       sealed;
  logic [CB-1:0]    cnt [2];
  logic [TOT_W-1:0] prodLeft, consLeft;
  logic             ovfQ, undQ, wDoneQ, rDoneQ;

  // transfer size in words, a partial word rounds up
  logic [TOT_W-1:0] totBytes;
  logic [TOT_W:0]   padBytes;
  logic [TOT_W-1:0] totWords;
  assign totBytes = TOT_W'(blkLen) * TOT_W'(blkCnt);
  assign padBytes = {1'b0, totBytes} + (TOT_W+1)'(3);
  assign totWords = padBytes[TOT_W:2];

  logic prodOpen, consAvail, swWrReady, swRdReady;
  assign prodOpen  = active && !sealed[prodSel] && (prodLeft != '0);
  assign consAvail = active && sealed[consSel];
  assign swWrReady = prodOpen && dirQ;
  assign swRdReady = consAvail && !dirQ;
  assign cardInReady  = prodOpen && !dirQ;
  assign cardOutValid = consAvail && dirQ;

  logic doPush, doPop, sealNow, lastPop, lastWord;
  assign doPush   = !start && (dirQ ? (swWr && swWrReady) : (cardInValid && cardInReady));
  assign doPop    = !start && (dirQ ? (cardOutTake && cardOutValid) : (swRd && swRdReady));
  assign sealNow  = doPush && ((cnt[prodSel] == CB'(DEPTH - 1)) || (prodLeft == TOT_W'(1)));
  assign lastPop  = cnt[consSel] == CB'(1);
  assign lastWord = doPop && (consLeft == TOT_W'(1));

  // sticky bit events
  logic ovfSet, undSet, wDoneSet, rDoneSet, startZero;
  assign ovfSet    = swWr && !swWrReady;
  assign undSet    = swRd && !swRdReady;
  assign startZero = start && (totWords == '0);
  assign wDoneSet  = (startZero && dirWrite) || (lastWord && dirQ);
  assign rDoneSet  = (startZero && !dirWrite) || (lastWord && !dirQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      dirQ     <= 1'b0;
      prodSel  <= 1'b0;
      consSel  <= 1'b0;
      sealed   <= '0;
      cnt[0]   <= '0;
      cnt[1]   <= '0;
      prodLeft <= '0;
      consLeft <= '0;
      ovfQ     <= 1'b0;
      undQ     <= 1'b0;
      wDoneQ   <= 1'b0;
      rDoneQ   <= 1'b0;
    end else begin
      ovfQ   <= (ovfQ   & ~(clrEn & clrMask[ST_OVF]))     | ovfSet;
      undQ   <= (undQ   & ~(clrEn & clrMask[ST_UND]))     | undSet;
      wDoneQ <= (wDoneQ & ~(clrEn & clrMask[ST_WR_DONE])) | wDoneSet;
      rDoneQ <= (rDoneQ & ~(clrEn & clrMask[ST_RD_DONE])) | rDoneSet;
      if (start) begin
        active   <= totWords != '0;
        dirQ     <= dirWrite;
        prodSel  <= 1'b0;
        consSel  <= 1'b0;
        sealed   <= '0;
        cnt[0]   <= '0;
        cnt[1]   <= '0;
        prodLeft <= totWords;
        consLeft <= totWords;
      end else begin
        for (int b = 0; b < 2; b++) begin
          cnt[b] <= cnt[b] + CB'(doPush && (prodSel == 1'(b)))
                           - CB'(doPop  && (consSel == 1'(b)));
        end
        if (sealNow) begin
          sealed[prodSel] <= 1'b1;
          prodSel         <= ~prodSel;
        end
        if (doPop && lastPop) begin
          sealed[consSel] <= 1'b0;
          consSel         <= ~consSel;
        end
        if (doPush) prodLeft <= prodLeft - 1'b1;
        if (doPop)  consLeft <= consLeft - 1'b1;
        if (lastWord) active <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.push    = doPush;
    ctl.pop     = doPop;
    ctl.prodSel = prodSel;
    ctl.consSel = consSel;
    ctl.relBuf  = doPop && lastPop;
    ctl.flush   = start;
  end

  always_comb begin
    status             = '0;
    status[ST_RD_RDY]  = swRdReady;
    status[ST_WR_RDY]  = swWrReady;
    status[ST_RD_DONE] = rDoneQ;
    status[ST_WR_DONE] = wDoneQ;
    status[ST_OVF]     = ovfQ;
    status[ST_UND]     = undQ;
    status[ST_X_FULL]  = cnt[0] == CB'(DEPTH);
    status[ST_Y_FULL]  = cnt[1] == CB'(DEPTH);
    status[ST_X_EMPTY] = cnt[0] == '0;
    status[ST_Y_EMPTY] = cnt[1] == '0;
  end
endmodule

// File: rtl/dbuf_port.sv
module dbuf_port
  import dbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dirWrite,
  input  logic [LEN_W-1:0]  blkLen,
  input  logic [CNT_W-1:0]  blkCnt,
  input  logic              swWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              swRd,
  output logic [DATA_W-1:0] rdData,
  input  logic              clrEn,
  input  logic [31:0]       clrMask,
  output logic [31:0]       status,
  output logic              cardOutValid,
  output logic [DATA_W-1:0] cardOutData,
  input  logic              cardOutTake,
  input  logic              cardInValid,
  input  logic [DATA_W-1:0] cardInData,
  output logic              cardInReady
);
  bufCtl_t           ctl;
  logic              dirQ;
  logic [DATA_W-1:0] headData;

  dbuf_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .dirWrite(dirWrite),
    .blkLen(blkLen), .blkCnt(blkCnt), .swWr(swWr), .swRd(swRd),
    .clrEn(clrEn), .clrMask(clrMask), .cardOutTake(cardOutTake),
    .cardInValid(cardInValid), .ctl(ctl), .dirQ(dirQ), .status(status),
    .cardOutValid(cardOutValid), .cardInReady(cardInReady)
  );

  dbuf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .pushData(dirQ ? wrData : cardInData),
    .headData(headData)
  );

  assign rdData      = headData;
  assign cardOutData = headData;
endmodule

// File: rtl/dbuf_checker.sv
module dbuf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        swWr,
  input logic        swRd,
  input logic        clrEn,
  input logic [31:0] clrMask,
  input logic [31:0] status,
  input logic        cardOutValid,
  input logic        cardInReady
);
  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swWr && !status[6]) |=> status[24]);

  assert_und_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swRd && !status[7]) |=> status[25]);

  assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[7]));

  assert_card_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cardOutValid && cardInReady));

  assert_occupancy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[28] && status[26]) && !(status[29] && status[27]));

  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[24] && !(clrEn && clrMask[24])) |=> status[24]);

  assert_sticky_wdone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[12] && !(clrEn && clrMask[12])) |=> status[12]);
endmodule

bind dbuf_port dbuf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .swWr(swWr), .swRd(swRd), .clrEn(clrEn),
  .clrMask(clrMask), .status(status), .cardOutValid(cardOutValid),
  .cardInReady(cardInReady)
);

// File: tb/test_dbuf_port.sv
module test_dbuf_port;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dirWrite = 1'b0;
  logic [11:0] blkLen = '0;
  logic [15:0] blkCnt = '0;
  logic        swWr = 1'b0, swRd = 1'b0, clrEn = 1'b0;
  logic [31:0] wrData = '0, clrMask = '0;
  logic [31:0] rdData, status, cardOutData;
  logic        cardOutValid, cardInReady;
  logic        cardOutTake = 1'b0, cardInValid = 1'b0;
  logic [31:0] cardInData = '0;

  always #2 clk = ~clk;

  dbuf_port #(.DEPTH(DEPTH)) i_dbuf_port (
    .clk(clk), .rst_n(rst_n), .start(start), .dirWrite(dirWrite),
    .blkLen(blkLen), .blkCnt(blkCnt), .swWr(swWr), .wrData(wrData),
    .swRd(swRd), .rdData(rdData), .clrEn(clrEn), .clrMask(clrMask),
    .status(status), .cardOutValid(cardOutValid), .cardOutData(cardOutData),
    .cardOutTake(cardOutTake), .cardInValid(cardInValid),
    .cardInData(cardInData), .cardInReady(cardInReady)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] expQ [256];
  int totalOverlap = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int expWords(int len, int cnt);
    return (len * cnt + 3) / 4;
  endfunction

  task automatic startXfer(input bit dw, input int len, input int cnt);
    dirWrite = dw; blkLen = 12'(len); blkCnt = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clearAll();
    clrEn = 1'b1; clrMask = 32'hFFFF_FFFF;
    @(negedge clk);
    clrEn = 1'b0; clrMask = '0;
  endtask

  task automatic runWrite(input int len, input int cnt, input int pSw, input int pCard);
    int n, wIdx, rIdx, guard;
    n = expWords(len, cnt); wIdx = 0; rIdx = 0; guard = 0;
    startXfer(1'b1, len, cnt);
    while (rIdx < n && guard < 4000) begin
      bit w, t;
      w = status[6] && (($urandom % 100) < pSw);
      t = cardOutValid && (($urandom % 100) < pCard);
      wrData = $urandom;
      swWr = w;
      if (w) begin expQ[wIdx] = wrData; wIdx++; end
      if (t) begin
        chk(cardOutData == expQ[rIdx], "R3 write order", cardOutData, expQ[rIdx]);
        rIdx++;
      end
      cardOutTake = t;
      if (w && t) totalOverlap++;
      @(negedge clk);
      guard++;
    end
    swWr = 1'b0; cardOutTake = 1'b0;
    chk(wIdx == n, "R2 words accepted", 32'(wIdx), 32'(n));
    chk(rIdx == n, "R2 words delivered", 32'(rIdx), 32'(n));
    chk(status[12] == 1'b1, "R8 write done", status, 32'h1000);
    chk(status[6] == 1'b0, "R3 ready low after end", status, 32'h0);
  endtask

  task automatic runRead(input int len, input int cnt, input int pCard, input int pSw);
    int n, wIdx, rIdx, guard;
    n = expWords(len, cnt); wIdx = 0; rIdx = 0; guard = 0;
    startXfer(1'b0, len, cnt);
    while (rIdx < n && guard < 4000) begin
      bit v, r;
      v = cardInReady && (($urandom % 100) < pCard);
      r = status[7] && (($urandom % 100) < pSw);
      cardInData = $urandom;
      cardInValid = v;
      if (v) begin expQ[wIdx] = cardInData; wIdx++; end
      if (r) begin
        chk(rdData == expQ[rIdx], "R4 read order", rdData, expQ[rIdx]);
        rIdx++;
      end
      swRd = r;
      if (v && r) totalOverlap++;
      @(negedge clk);
      guard++;
    end
    swRd = 1'b0; cardInValid = 1'b0;
    chk(wIdx == n, "R2 words accepted", 32'(wIdx), 32'(n));
    chk(rIdx == n, "R2 words delivered", 32'(rIdx), 32'(n));
    chk(status[11] == 1'b1, "R8 read done", status, 32'h800);
    chk(cardInReady == 1'b0, "R4 card ready low after end", 32'(cardInReady), 32'h0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(status == 32'h3000_0000, "R1 reset status", status, 32'h3000_0000);

    // R6: overflow while idle, word dropped
    swWr = 1'b1; @(negedge clk); swWr = 1'b0;
    chk(status[24] == 1'b1, "R6 overflow set", status, 32'h0100_0000);
    chk(status[29:28] == 2'b11, "R6 nothing stored", status, 32'h3000_0000);
    // R7: underrun while idle
    swRd = 1'b1; @(negedge clk); swRd = 1'b0;
    chk(status[25] == 1'b1, "R7 underrun set", status, 32'h0200_0000);
    // R9: selective clear
    clrEn = 1'b1; clrMask = 32'h0100_0000; @(negedge clk); clrEn = 1'b0;
    chk(status == 32'h3200_0000, "R9 clear only bit 24", status, 32'h3200_0000);
    // R9: set wins over clear in the same cycle
    swWr = 1'b1; clrEn = 1'b1; clrMask = 32'h0100_0000; @(negedge clk);
    swWr = 1'b0; clrEn = 1'b0;
    chk(status[24] == 1'b1, "R9 set beats clear", status, 32'h0100_0000);
    clearAll();
    chk(status == 32'h3000_0000, "R9 clear all keeps live bits", status, 32'h3000_0000);

    // R2: zero length transfer
    startXfer(1'b0, 0, 3);
    chk(status == 32'h3000_0800, "R2 zero length read done", status, 32'h3000_0800);
    clearAll();

    // R5/R11: five words, card idle -> X full, Y partial
    startXfer(1'b1, 20, 1);
    for (int i = 0; i < 5; i++) begin
      wrData = 32'hA000_0000 + 32'(i); swWr = status[6]; expQ[i] = wrData;
      @(negedge clk);
    end
    swWr = 1'b0;
    chk(status[29:26] == 4'b0001, "R5 X full Y partial", {28'b0, status[29:26]}, 32'h1);
    chk(status[6] == 1'b0, "R3 no room after last word", status, 32'h0);
    swWr = 1'b1; wrData = 32'hDEAD_BEEF; @(negedge clk); swWr = 1'b0;
    chk(status[24] == 1'b1, "R6 overflow during transfer", status, 32'h0100_0000);
    for (int i = 0; i < 5; i++) begin
      chk(cardOutValid == 1'b1, "R11 card valid", 32'(cardOutValid), 32'h1);
      chk(cardOutData == expQ[i], "R11 partial buffer data", cardOutData, expQ[i]);
      cardOutTake = 1'b1; @(negedge clk); cardOutTake = 1'b0;
    end
    chk(status == 32'h3100_1000, "R8 write done, buffers empty", status, 32'h3100_1000);
    clearAll();

    // R5: eight words fill both buffers
    startXfer(1'b1, 32, 1);
    for (int i = 0; i < 8; i++) begin
      wrData = 32'h5000_0000 + 32'(i); swWr = 1'b1; @(negedge clk);
    end
    swWr = 1'b0;
    chk(status[29:26] == 4'b0011, "R5 both full", {28'b0, status[29:26]}, 32'h3);
    chk(cardOutData == 32'h5000_0000, "R3 X drains first", cardOutData, 32'h5000_0000);
    for (int i = 0; i < 8; i++) begin
      chk(cardOutData == 32'h5000_0000 + 32'(i), "R3 X then Y order",
          cardOutData, 32'h5000_0000 + 32'(i));
      cardOutTake = 1'b1; @(negedge clk); cardOutTake = 1'b0;
    end
    clearAll();

    // R7: read with nothing ready during a read transfer
    startXfer(1'b0, 8, 1);
    swRd = 1'b1; @(negedge clk); swRd = 1'b0;
    chk(status[25] == 1'b1, "R7 underrun in transfer", status, 32'h0200_0000);
    chk(cardInReady == 1'b1, "R7 nothing consumed", 32'(cardInReady), 32'h1);
    clearAll();

    // random transfers (R2, R3, R4, R8, R10)
    for (int k = 0; k < 8; k++) begin
      runWrite(1 + int'($urandom % 48), 1 + int'($urandom % 4), 60 + int'($urandom % 40), 60 + int'($urandom % 40));
      clearAll();
      runRead(1 + int'($urandom % 48), 1 + int'($urandom % 4), 60 + int'($urandom % 40), 60 + int'($urandom % 40));
      clearAll();
    end
    chk(totalOverlap > 0, "R10 push and pop same cycle", 32'(totalOverlap), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule